// File: doc/BRIEF.md
# Write Access Pre-Check Sequencer

This block sits between a requester and a serial-memory transaction engine and guards every write, sector erase, chip erase and protection-setting request. An accepted request is first screened locally: if the engine is not idle, the request fails as busy at once, and if the target address falls outside the device capacity it fails as out of range. Neither case puts any command on the engine. Otherwise the block reads the memory status byte. It aborts on a busy device. It judges the block-protection field against the request. It then issues a write-enable and finally launches the program or erase command.

For a protection-setting request the block writes the status byte after a write-enable. It then reads the byte back, polling while the device reports busy, and compares the protection field. A mismatch shows that the hardware write-protect input of the memory is active, and the block reports that case. Each request ends with a 3-bit result code and a one-cycle done pulse. The code stays on its output until the next request finishes.

The state machine has these states: `S_IDLE` (waiting), `S_STAT`/`S_STAT_W` (issue and await the guarding status read), `S_WEN`/`S_WEN_W` (issue and await write-enable), `S_WSR`/`S_WSR_W` (issue and await the status write), `S_CHK`/`S_CHK_W` (issue and await the read-back), and `S_LAUNCH` (one-cycle launch of the program or erase command). The transitions are as follows:
- IDLE→IDLE on an immediate reject, and IDLE→STAT on an accepted request that passes the screening.
- STAT→STAT_W always.
- STAT_W→IDLE on busy or a protection hit, and STAT_W→WEN otherwise.
- WEN→WEN_W always.
- WEN_W→WSR for a protection-setting request, and WEN_W→LAUNCH otherwise.
- WSR→WSR_W→CHK→CHK_W.
- CHK_W→CHK while the device reads busy, and CHK_W→IDLE with the verdict.
- LAUNCH→IDLE always.

Top module: `wp_precheck_seq`

## Requirements
- R1: A request accepted while `eng_idle` is low finishes with code 1 (busy) on the cycle after acceptance, and no command is issued.
- R2: A write whose last byte (`req_addr + req_len`) is at or above `MEM_BYTES`, or a sector erase whose address is at or above `MEM_BYTES`, finishes with code 2 (out of range) and issues no command. Chip erase and protection setting are never out of range.
- R3: The first command of every request that passes the screening is a status read (command code 0).
- R4: When the guarding status read returns bit 0 set (device busy), the request finishes with code 1 and issues no further command. The busy check takes priority over the protection bits, which read as all ones during a write cycle.
- R5: The protection field is status bits [3:2]. Code 01 protects addresses from `MEM_BYTES - MEM_BYTES/4` upward, code 10 protects addresses from `MEM_BYTES/2` upward, and code 11 protects the whole array. A write whose last byte falls in the protected area finishes with code 3.
- R6: A sector erase is judged by its address. A chip erase counts as protected for any non-zero protection code. A hit finishes with code 3.
- R7: A write-enable (command code 1) is issued and completes immediately before every status write (code 2), program (code 3), sector erase (code 4) and chip erase (code 5).
- R8: A request that passes all checks launches its command carrying `addr` and `len` and finishes with code 0 in the cycle after the launch.
- R9: A protection-setting request writes `req_bp` into bits [3:2] of the status byte and then reads the byte back. If the read-back field differs, it finishes with code 4 (hardware protected); otherwise it finishes with code 0.
- R10: While the read-back status shows bit 0 set, the block re-issues the status read until the device is ready.
- R11: `rsp_done` is high for exactly one cycle per request. `rsp_code` is 0 after reset and holds its value between completions.
- R12: `req_ready` is high only in the idle state with no done pulse pending. A request presented while it is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 write, 1 sector erase, 2 chip erase, 3 set protection |
| req_addr | input | ADDR_W | Start address or sector address |
| req_len | input | LEN_W | Data byte count minus one |
| req_bp | input | 2 | Protection code to set |
| eng_idle | input | 1 | Transaction engine is idle |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_op | output | 3 | 0 status read, 1 write-enable, 2 status write, 3 program, 4 sector erase, 5 chip erase |
| cmd_addr | output | ADDR_W | Address for a launched command |
| cmd_len | output | LEN_W | Byte count minus one for a launched program |
| cmd_wdata | output | 8 | Status byte for a status write |
| cmd_done | input | 1 | Engine finished the pending status read, write-enable or status write |
| cmd_rdata | input | 8 | Status byte returned with `cmd_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 3 | 0 complete, 1 busy, 2 out of range, 3 write protected, 4 hardware protected |

## Verification
The bench builds the block with a 12-bit address, a 4-bit length and a capacity of 3000 bytes. Because the capacity is not a power of two, addresses from 3000 to 4095 are representable, so the range check is exercised by real out-of-range inputs and not only by carry overflow. The quarter and half boundaries fall at 2250 and 1500, which lets a 16-byte page straddle each of them. An engine model with a random latency of 1 to 3 cycles covers every wait state, and a read-back delay of up to two busy reads covers the polling loop.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        RQ_WRITE = 2'd0,
        RQ_SECT  = 2'd1,
        RQ_CHIP  = 2'd2,
        RQ_PROT  = 2'd3
    } rq_op_e;

    typedef enum logic [2:0] {
        CM_RDSR   = 3'd0,
        CM_WREN   = 3'd1,
        CM_WRSR   = 3'd2,
        CM_PROG   = 3'd3,
        CM_SERASE = 3'd4,
        CM_CERASE = 3'd5
    } cm_op_e;

    typedef enum logic [2:0] {
        RC_DONE   = 3'd0,
        RC_BUSY   = 3'd1,
        RC_RANGE  = 3'd2,
        RC_WPROT  = 3'd3,
        RC_HWPROT = 3'd4
    } rc_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT,
        S_STAT_W,
        S_WEN,
        S_WEN_W,
        S_WSR,
        S_WSR_W,
        S_CHK,
        S_CHK_W,
        S_LAUNCH
    } st_e;

endpackage

// File: rtl/pcs_range_check.sv
module pcs_range_check
    import pcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 6,
    parameter int MEM_BYTES = 49152
) (
    input  rq_op_e              op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LEN_W-1:0]    len,
    output logic [ADDR_W:0]     last,
    output logic                oor
);
    localparam int XW = ADDR_W + 1;

    logic [XW-1:0] base;
    logic          oor_wr;
    logic          oor_base;

    assign base = {1'b0, addr};
    assign last = base + XW'(len);

    generate
        if (MEM_BYTES >= (1 << ADDR_W)) begin : g_full
            // every start address exists; only a page running past the top fails
            assign oor_wr   = last[ADDR_W];
            assign oor_base = 1'b0;
        end else begin : g_part
            localparam logic [XW-1:0] LIM = XW'(MEM_BYTES);
            assign oor_wr   = (last >= LIM);
            assign oor_base = (base >= LIM);
        end
    endgenerate

    always_comb begin
        unique case (op)
            RQ_WRITE: oor = oor_wr;
            RQ_SECT:  oor = oor_base;
            default:  oor = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcs_wp_region.sv
module pcs_wp_region #(
    parameter int PW        = 17,
    parameter int MEM_BYTES = 49152
) (
    input  logic [1:0]    bp,
    input  logic [PW-1:0] probe,
    input  logic          whole,
    output logic          hit
);
    logic [3:0] over;

    assign over[0] = 1'b0;

    generate
        for (genvar g = 1; g < 4; g++) begin : g_code
            if (g == 3) begin : g_all
                assign over[g] = 1'b1;
            end else begin : g_part
                localparam int BASE = (g == 1) ? (MEM_BYTES - MEM_BYTES / 4)
                                               : (MEM_BYTES / 2);
                assign over[g] = (probe >= PW'(BASE));
            end
        end
    endgenerate

    assign hit = (bp != 2'b00) && (whole || over[bp]);

endmodule

// File: rtl/wp_precheck_seq.sv
module wp_precheck_seq
    import pcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 6,
    parameter int MEM_BYTES = 49152,
    parameter int BP_LSB    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_bp,
    input  logic              eng_idle,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [7:0]        cmd_wdata,
    input  logic              cmd_done,
    input  logic [7:0]        cmd_rdata,
    output logic              rsp_done,
    output logic [2:0]        rsp_code
);
    localparam int       PW        = ADDR_W + 1;
    localparam logic [7:0] PROT_MASK = 8'h03 << BP_LSB;

    st_e               state_q, nxt;
    rq_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        bp_q;
    logic [PW-1:0]     probe_q;
    rc_e               code_q;
    logic              done_q;
    cm_op_e            last_cmd_q;

    logic              fin;
    rc_e               fin_code;
    cm_op_e            cmd_kind;
    logic              accept;
    rq_op_e            req_kind;
    logic [PW-1:0]     req_last;
    logic              rng_oor;
    logic              wp_hit;
    logic              st_busy;
    logic [1:0]        st_bp;
    logic [7:0]        wsr_byte;
    logic              rb_match;

    assign req_kind = rq_op_e'(req_op);
    assign req_ready = (state_q == S_IDLE) && !done_q;
    assign accept = req_valid && req_ready;

    pcs_range_check #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .MEM_BYTES(MEM_BYTES)
    ) i_range (
        .op  (req_kind),
        .addr(req_addr),
        .len (req_len),
        .last(req_last),
        .oor (rng_oor)
    );

    assign st_busy  = cmd_rdata[0];
    assign st_bp    = cmd_rdata[BP_LSB +: 2];
    assign wsr_byte = {6'd0, bp_q} << BP_LSB;
    assign rb_match = ((cmd_rdata ^ wsr_byte) & PROT_MASK) == 8'h00;

    pcs_wp_region #(
        .PW       (PW),
        .MEM_BYTES(MEM_BYTES)
    ) i_region (
        .bp   (st_bp),
        .probe(probe_q),
        .whole(op_q == RQ_CHIP),
        .hit  (wp_hit)
    );

    // next state and verdict
    always_comb begin
        nxt      = state_q;
        fin      = 1'b0;
        fin_code = RC_DONE;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (!eng_idle) begin
                        fin      = 1'b1;
                        fin_code = RC_BUSY;
                    end else if (rng_oor) begin
                        fin      = 1'b1;
                        fin_code = RC_RANGE;
                    end else begin
                        nxt = S_STAT;
                    end
                end
            end
            S_STAT: nxt = S_STAT_W;
            S_STAT_W: begin
                if (cmd_done) begin
                    if (st_busy) begin
                        fin      = 1'b1;
                        fin_code = RC_BUSY;
                        nxt      = S_IDLE;
                    end else if (op_q != RQ_PROT && wp_hit) begin
                        fin      = 1'b1;
                        fin_code = RC_WPROT;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = S_WEN;
                    end
                end
            end
            S_WEN: nxt = S_WEN_W;
            S_WEN_W: begin
                if (cmd_done) begin
                    nxt = (op_q == RQ_PROT) ? S_WSR : S_LAUNCH;
                end
            end
            S_WSR: nxt = S_WSR_W;
            S_WSR_W: begin
                if (cmd_done) begin
                    nxt = S_CHK;
                end
            end
            S_CHK: nxt = S_CHK_W;
            S_CHK_W: begin
                if (cmd_done) begin
                    if (st_busy) begin
                        nxt = S_CHK;
                    end else begin
                        fin      = 1'b1;
                        fin_code = rb_match ? RC_DONE : RC_HWPROT;
                        nxt      = S_IDLE;
                    end
                end
            end
            S_LAUNCH: begin
                fin      = 1'b1;
                fin_code = RC_DONE;
                nxt      = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= RQ_WRITE;
            addr_q     <= '0;
            len_q      <= '0;
            bp_q       <= 2'b00;
            probe_q    <= '0;
            code_q     <= RC_DONE;
            done_q     <= 1'b0;
            last_cmd_q <= CM_RDSR;
        end else begin
            state_q <= nxt;
            done_q  <= fin;
            if (fin) begin
                code_q <= fin_code;
            end
            if (accept) begin
                op_q    <= req_kind;
                addr_q  <= req_addr;
                len_q   <= req_len;
                bp_q    <= req_bp;
                probe_q <= (req_kind == RQ_WRITE) ? req_last : {1'b0, req_addr};
            end
            if (cmd_valid) begin
                last_cmd_q <= cmd_kind;
            end
        end
    end

    // command outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = CM_RDSR;
        unique case (state_q)
            S_STAT, S_CHK: begin
                cmd_valid = 1'b1;
                cmd_kind  = CM_RDSR;
            end
            S_WEN: begin
                cmd_valid = 1'b1;
                cmd_kind  = CM_WREN;
            end
            S_WSR: begin
                cmd_valid = 1'b1;
                cmd_kind  = CM_WRSR;
            end
            S_LAUNCH: begin
                cmd_valid = 1'b1;
                unique case (op_q)
                    RQ_SECT: cmd_kind = CM_SERASE;
                    RQ_CHIP: cmd_kind = CM_CERASE;
                    default: cmd_kind = CM_PROG;
                endcase
            end
            default: begin
                cmd_valid = 1'b0;
                cmd_kind  = CM_RDSR;
            end
        endcase
    end

    assign cmd_op    = cmd_kind;
    assign cmd_addr  = addr_q;
    assign cmd_len   = len_q;
    assign cmd_wdata = wsr_byte;
    assign rsp_done  = done_q;
    assign rsp_code  = code_q;

    // ---------------- assertions ----------------
    p_idle_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !eng_idle) |=> (rsp_done && rsp_code == 3'd1 && !cmd_valid));

    p_range_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eng_idle && rng_oor) |=> (rsp_done && rsp_code == 3'd2 && !cmd_valid));

    p_first_is_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!cmd_valid || cmd_op == 3'd0));

    p_busy_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STAT_W && cmd_done && cmd_rdata[0]) |=> (rsp_done && rsp_code == 3'd1));

    p_wren_before_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op >= 3'd2) |-> (last_cmd_q == CM_WREN));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_code <= 3'd4));

    p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !accept) |=> $stable(rsp_code));

    p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

endmodule

// File: tb/test_wp_precheck_seq.sv
module test_wp_precheck_seq;
    localparam int AW  = 12;
    localparam int LW  = 4;
    localparam int MEM = 3000;

    logic          clk, rst_n;
    logic          req_valid, req_ready;
    logic [1:0]    req_op, req_bp;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic          eng_idle;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;
    logic [7:0]    cmd_wdata;
    logic          cmd_done;
    logic [7:0]    cmd_rdata;
    logic          rsp_done;
    logic [2:0]    rsp_code;

    wp_precheck_seq #(.ADDR_W(AW), .LEN_W(LW), .MEM_BYTES(MEM), .BP_LSB(2)) i_wp_precheck_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_bp(req_bp),
        .eng_idle(eng_idle),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .rsp_done(rsp_done), .rsp_code(rsp_code)
    );

    // memory / engine model state
    logic [1:0] m_bp, cfg_bp;
    logic       cfg_load;
    logic       m_busy, m_wp_low;
    int         m_retry_cfg, lat, retry_left, pend_cnt;
    logic [7:0] pend_rd;
    logic [2:0]    lg_op  [2048];
    logic [AW-1:0] lg_addr[2048];
    logic [LW-1:0] lg_len [2048];
    logic [7:0]    lg_dat [2048];
    int log_n, done_cnt;
    int checks, errs;
    logic [1:0] sh_bp;

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_done <= 1'b0; cmd_rdata <= 8'h00; pend_cnt <= 0; pend_rd <= 8'h00;
            retry_left <= 0; log_n <= 0; done_cnt <= 0; m_bp <= 2'b00;
        end else begin
            cmd_done <= 1'b0;
            if (cfg_load) m_bp <= cfg_bp;
            if (rsp_done) done_cnt <= done_cnt + 1;
            if (pend_cnt == 1) begin
                cmd_done  <= 1'b1;
                cmd_rdata <= pend_rd;
            end
            if (pend_cnt > 0) pend_cnt <= pend_cnt - 1;
            if (cmd_valid) begin
                lg_op[log_n % 2048]   <= cmd_op;
                lg_addr[log_n % 2048] <= cmd_addr;
                lg_len[log_n % 2048]  <= cmd_len;
                lg_dat[log_n % 2048]  <= cmd_wdata;
                log_n <= log_n + 1;
                case (cmd_op)
                    3'd0: begin
                        pend_rd <= (m_busy || retry_left > 0) ? 8'hFF : {4'h0, m_bp, 2'b00};
                        if (retry_left > 0) retry_left <= retry_left - 1;
                        pend_cnt <= lat;
                    end
                    3'd1: pend_cnt <= lat;
                    3'd2: begin
                        if (!m_wp_low) m_bp <= cmd_wdata[3:2];
                        retry_left <= m_retry_cfg;
                        pend_cnt <= lat;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tg, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
        end
    endtask

    function automatic bit exp_oor(input int op, input int addr, input int len);
        if (op == 0) return (addr + len) >= MEM;
        if (op == 1) return addr >= MEM;
        return 1'b0;
    endfunction

    function automatic bit exp_hit(input int op, input int addr, input int len, input int bp);
        int probe;
        if (bp == 0) return 1'b0;
        if (op == 2 || bp == 3) return 1'b1;
        probe = (op == 0) ? addr + len : addr;
        if (bp == 1) return probe >= (MEM - MEM / 4);
        return probe >= (MEM / 2);
    endfunction

    task automatic setmem(input int bp, input bit busy, input bit wp, input int retry, input int l);
        @(negedge clk);
        cfg_bp = 2'(bp); cfg_load = 1'b1;
        m_busy = busy; m_wp_low = wp; m_retry_cfg = retry; lat = l;
        sh_bp = 2'(bp);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic run(input int op, input int addr, input int len, input int bp, input bit hold2);
        int eo[12];
        int en, ecode, sl, sd, t;
        string tg;
        en = 0;
        if (!eng_idle) begin ecode = 1; tg = "R1"; end
        else if (exp_oor(op, addr, len)) begin ecode = 2; tg = "R2"; end
        else begin
            eo[en++] = 0;
            if (m_busy) begin ecode = 1; tg = "R4"; end
            else if (op == 3) begin
                eo[en++] = 1; eo[en++] = 2;
                for (int r = 0; r <= m_retry_cfg; r++) eo[en++] = 0;
                ecode = ((m_wp_low ? int'(sh_bp) : bp) == bp) ? 0 : 4;
                tg = (m_retry_cfg > 0) ? "R10" : "R9";
                if (!m_wp_low) sh_bp = 2'(bp);
            end else if (exp_hit(op, addr, len, bp == bp ? int'(sh_bp) : 0)) begin
                ecode = 3; tg = (op == 0) ? "R5" : "R6";
            end else begin
                eo[en++] = 1; eo[en++] = 3 + op; ecode = 0; tg = "R8";
            end
        end
        @(negedge clk);
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        sl = log_n; sd = done_cnt;
        req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr); req_len = LW'(len); req_bp = 2'(bp);
        @(negedge clk);
        if (hold2) begin
            req_op = 2'(op ^ 1); req_addr = req_addr ^ 12'h155;  // R12: must be ignored
            @(negedge clk);
        end
        req_valid = 1'b0;
        t = 0;
        while (done_cnt == sd && t < 300) begin @(negedge clk); t++; end
        chk("R11", "completion seen", int'(done_cnt > sd), 1);
        chk(tg, "result code", int'(rsp_code), ecode);
        repeat (3) @(negedge clk);
        chk("R12", "single completion", done_cnt - sd, 1);
        chk(tg, "code held", int'(rsp_code), ecode);
        chk("R3", "command count", log_n - sl, en);
        for (int k = 0; k < en && k < log_n - sl; k++)
            chk("R7", "command order", int'(lg_op[(sl + k) % 2048]), eo[k]);
        if (ecode == 0 && op < 3 && log_n - sl == 3) begin
            chk("R8", "launch address", int'(lg_addr[(sl + 2) % 2048]), addr);
            chk("R8", "launch length", int'(lg_len[(sl + 2) % 2048]), len);
        end
        if (op == 3 && log_n - sl >= 3)
            chk("R9", "status write byte", int'(lg_dat[(sl + 2) % 2048]), bp * 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        checks = 0; errs = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_len = '0; req_bp = 2'd0;
        eng_idle = 1'b1; cfg_load = 1'b0; cfg_bp = 2'd0; m_busy = 1'b0; m_wp_low = 1'b0;
        m_retry_cfg = 0; lat = 1; sh_bp = 2'd0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset done", int'(rsp_done), 0);
        chk("R11", "reset code", int'(rsp_code), 0);
        chk("R12", "reset ready", int'(req_ready), 1);
        chk("R3", "reset no command", int'(cmd_valid), 0);

        // R1 engine not idle
        setmem(0, 0, 0, 0, 1);
        eng_idle = 1'b0; run(0, 10, 3, 0, 1'b0); eng_idle = 1'b1;
        // R2 range boundaries
        run(0, 2990, 9, 0, 1'b0);
        run(0, 2991, 9, 0, 1'b0);
        run(1, 3000, 0, 0, 1'b0);
        run(1, 2999, 0, 0, 1'b1);
        run(2, 4095, 15, 0, 1'b0);
        // R4 busy dominates all-ones protection bits
        setmem(0, 1, 0, 0, 2);
        run(0, 100, 0, 0, 1'b0);
        // R5 write region boundaries
        setmem(1, 0, 0, 0, 1);
        run(0, 2240, 9, 0, 1'b0);
        run(0, 2240, 10, 0, 1'b0);
        setmem(2, 0, 0, 0, 3);
        run(0, 1490, 9, 0, 1'b0);
        run(0, 1500, 0, 0, 1'b0);
        setmem(3, 0, 0, 0, 1);
        run(0, 0, 0, 0, 1'b0);
        // R6 erase protection
        setmem(1, 0, 0, 0, 2);
        run(1, 2250, 0, 0, 1'b0);
        run(1, 2249, 0, 0, 1'b0);
        run(2, 0, 0, 0, 1'b0);
        setmem(0, 0, 0, 0, 1);
        run(2, 0, 0, 0, 1'b0);
        // R9 protection setting and hardware-protect detection
        run(3, 0, 0, 2, 1'b0);
        m_wp_low = 1'b1;
        run(3, 0, 0, 1, 1'b0);
        run(3, 0, 0, 2, 1'b0);
        m_wp_low = 1'b0;
        // R10 busy read-back polling
        m_retry_cfg = 2;
        run(3, 0, 0, 3, 1'b1);
        m_retry_cfg = 0;

        for (int i = 0; i < 400; i++) begin
            setmem($urandom_range(0, 3), ($urandom_range(0, 99) < 15), ($urandom_range(0, 99) < 20),
                   $urandom_range(0, 2), $urandom_range(1, 3));
            eng_idle = ($urandom_range(0, 99) >= 10);
            run($urandom_range(0, 3), $urandom_range(0, 4095), $urandom_range(0, 15),
                $urandom_range(0, 3), $urandom_range(0, 1));
            eng_idle = 1'b1;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule